// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside a free-running 16-bit up-counter owned by a timer. On every clock it compares the counter value with a programmed compare value. From that comparison and a 3-bit mode field it maintains an internal reference level. The modes are: hold, set on match, clear on match, toggle on match, force low, force high, and two pulse-width forms.

The reference then feeds two pins. The main pin carries the reference and the complementary pin carries its inverse. Each pin has its own polarity and enable input, and a master output enable gates both pins. A disabled pin rests at 0. A registered match flag pulses for one cycle after each equality, and an interrupt request follows it when the channel's interrupt enable is set. The counter, dead-time insertion, break handling and the register interface sit outside this block.

Top module: `cmp_out_channel`

## Requirements
- R1: With mode 000 (hold) the reference keeps its value on every clock, whatever the comparison gives.
- R2: With mode 001 the reference becomes 1 on the clock edge where cnt_i equals cmp_val_i. With mode 010 it becomes 0 on that edge. In both modes it keeps its value on every other edge.
- R3: With mode 011 the reference inverts on each clock edge where cnt_i equals cmp_val_i and otherwise keeps its value.
- R4: Mode 100 drives the reference to 0 and mode 101 drives it to 1 at the next clock edge, whatever the comparison gives.
- R5: Mode 110 sets the reference at the next edge to 1 when cnt_i < cmp_val_i (unsigned) and to 0 otherwise. Mode 111 sets it to 0 when cnt_i < cmp_val_i and to 1 otherwise.
- R6: When enabled, main_o equals the reference XOR main_pol_i, so main_pol_i=1 makes the pin active low.
- R7: When enabled, comp_o equals the inverted reference XOR comp_pol_i.
- R8: When main_en_i (or comp_en_i) is 0, main_o (or comp_o) is 0, whatever the reference is.
- R9: When master_en_i is 0, both main_o and comp_o are 0. Each pin follows R6/R7 only when master_en_i and its own enable are both 1.
- R10: match_o is 1 for exactly the cycle after a clock edge at which cnt_i equalled cmp_val_i. irq_o is 1 in that cycle only if irq_en_i was also 1 at that edge.
- R11: While rst_ni is low, the reference, match_o and irq_o are 0. With both pins enabled at polarity 0, main_o is then 0 and comp_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Counter value |
| cmp_val_i | input | 16 | Compare value |
| mode_i | input | 3 | Reference mode |
| main_pol_i | input | 1 | Main pin polarity (1 = active low) |
| main_en_i | input | 1 | Main pin enable |
| comp_pol_i | input | 1 | Complementary pin polarity (1 = active low) |
| comp_en_i | input | 1 | Complementary pin enable |
| master_en_i | input | 1 | Master output enable for both pins |
| irq_en_i | input | 1 | Interrupt enable for the match flag |
| main_o | output | 1 | Main output pin |
| comp_o | output | 1 | Complementary output pin |
| match_o | output | 1 | One-cycle match flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The properties assume that every input is synchronous to clk_i, free of X, and stable around the rising edge. They also assume that the mode and compare value seen at an edge are the ones that define the next reference. The stimulus meets these assumptions by changing inputs only on the falling edge. It sweeps the counter across the compare value in every mode and polarity pairing, and it includes a compare value of zero, a compare value at the top of the range, and counter wrap-around. A random phase then mixes modes, enables and nearby compare values so that matches keep occurring.

// File: rtl/cmp_out_pkg.sv
`timescale 1ns/1ps
package cmp_out_pkg;
  typedef enum logic [2:0] {
    OC_HOLD   = 3'b000,
    OC_SET    = 3'b001,
    OC_CLR    = 3'b010,
    OC_TOG    = 3'b011,
    OC_LOW    = 3'b100,
    OC_HIGH   = 3'b101,
    OC_PWM_LO = 3'b110,
    OC_PWM_HI = 3'b111
  } oc_mode_e;

  localparam int unsigned NUM_PINS = 2;
endpackage

// File: rtl/cmp_match_unit.sv
`timescale 1ns/1ps
module cmp_match_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             eq_o,
  output logic             below_o
);
  always_comb begin
    eq_o    = (cnt_i == cmp_i);
    below_o = (cnt_i < cmp_i);
  end
endmodule

// File: rtl/cmp_ref_gen.sv
`timescale 1ns/1ps
module cmp_ref_gen
  import cmp_out_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  oc_mode_e mode_i,
  input  logic     eq_i,
  input  logic     below_i,
  output logic     ref_o
);
  logic ref_q, ref_d;

  always_comb begin
    ref_d = ref_q;
    unique case (mode_i)
      OC_HOLD:   ref_d = ref_q;
      OC_SET:    if (eq_i) ref_d = 1'b1;
      OC_CLR:    if (eq_i) ref_d = 1'b0;
      OC_TOG:    if (eq_i) ref_d = ~ref_q;
      OC_LOW:    ref_d = 1'b0;
      OC_HIGH:   ref_d = 1'b1;
      OC_PWM_LO: ref_d = below_i;
      OC_PWM_HI: ref_d = ~below_i;
      default:   ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_d;
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/cmp_out_stage.sv
`timescale 1ns/1ps
module cmp_out_stage #(
  parameter bit IDLE_LVL = 1'b0
) (
  input  logic ref_i,
  input  logic pol_i,
  input  logic en_i,
  input  logic master_i,
  output logic pin_o
);
  always_comb begin
    if (master_i && en_i) pin_o = ref_i ^ pol_i;
    else                  pin_o = IDLE_LVL;
  end
endmodule

// File: rtl/cmp_flag_reg.sv
`timescale 1ns/1ps
module cmp_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eq_i,
  input  logic irq_en_i,
  output logic match_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      match_o <= eq_i;
      irq_o   <= eq_i & irq_en_i;
    end
  end
endmodule

// File: rtl/cmp_out_channel.sv
`timescale 1ns/1ps
module cmp_out_channel
  import cmp_out_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic [2:0]       mode_i,
  input  logic             main_pol_i,
  input  logic             main_en_i,
  input  logic             comp_pol_i,
  input  logic             comp_en_i,
  input  logic             master_en_i,
  input  logic             irq_en_i,
  output logic             main_o,
  output logic             comp_o,
  output logic             match_o,
  output logic             irq_o
);
  logic eq, below, ref_q;
  logic [NUM_PINS-1:0] pin_ref, pin_pol, pin_en, pin_out;

  cmp_match_unit #(.CNT_W(CNT_W)) i_match (
    .cnt_i   (cnt_i),
    .cmp_i   (cmp_val_i),
    .eq_o    (eq),
    .below_o (below)
  );

  cmp_ref_gen i_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (oc_mode_e'(mode_i)),
    .eq_i    (eq),
    .below_i (below),
    .ref_o   (ref_q)
  );

  // lane 0: main pin, lane 1: complementary pin
  assign pin_ref = {~ref_q, ref_q};
  assign pin_pol = {comp_pol_i, main_pol_i};
  assign pin_en  = {comp_en_i, main_en_i};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    cmp_out_stage #(.IDLE_LVL(1'b0)) i_stage (
      .ref_i    (pin_ref[g]),
      .pol_i    (pin_pol[g]),
      .en_i     (pin_en[g]),
      .master_i (master_en_i),
      .pin_o    (pin_out[g])
    );
  end

  assign main_o = pin_out[0];
  assign comp_o = pin_out[1];

  cmp_flag_reg i_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eq_i     (eq),
    .irq_en_i (irq_en_i),
    .match_o  (match_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/cmp_out_channel_chk.sv
`timescale 1ns/1ps
module cmp_out_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_val_i,
  input logic [2:0]       mode_i,
  input logic             ref_i,
  input logic             master_en_i,
  input logic             main_en_i,
  input logic             irq_en_i,
  input logic             main_o,
  input logic             comp_o,
  input logic             match_o,
  input logic             irq_o
);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b000) |=> $stable(ref_i));

  p_set_on_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b001 && cnt_i == cmp_val_i) |=> ref_i);

  p_clr_on_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b010 && cnt_i == cmp_val_i) |=> !ref_i);

  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b011 && cnt_i == cmp_val_i) |=> (ref_i != $past(ref_i)));

  p_force_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b100) |=> !ref_i);

  p_force_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b101) |=> ref_i);

  p_pwm_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b110 && cnt_i < cmp_val_i) |=> ref_i);

  p_pwm_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b111 && cnt_i < cmp_val_i) |=> !ref_i);

  p_main_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_en_i |-> !main_o);

  p_master_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en_i |-> (!main_o && !comp_o));

  p_match_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == cmp_val_i) |=> match_o);

  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == cmp_val_i && irq_en_i) |=> irq_o);

  p_irq_needs_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> match_o);
endmodule

bind cmp_out_channel cmp_out_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_i       (cnt_i),
  .cmp_val_i   (cmp_val_i),
  .mode_i      (mode_i),
  .ref_i       (ref_q),
  .master_en_i (master_en_i),
  .main_en_i   (main_en_i),
  .irq_en_i    (irq_en_i),
  .main_o      (main_o),
  .comp_o      (comp_o),
  .match_o     (match_o),
  .irq_o       (irq_o)
);

// File: tb/test_cmp_out_channel.sv
`timescale 1ns/1ps
module test_cmp_out_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt, cmp;
  logic [2:0]  mode;
  logic        main_pol, main_en, comp_pol, comp_en, master, irq_en;
  logic        main_o, comp_o, match_o, irq_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic m_ref = 1'b0;

  always #2.5 clk = ~clk;

  cmp_out_channel i_cmp_out_channel (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cmp_val_i(cmp), .mode_i(mode),
    .main_pol_i(main_pol), .main_en_i(main_en), .comp_pol_i(comp_pol),
    .comp_en_i(comp_en), .master_en_i(master), .irq_en_i(irq_en),
    .main_o(main_o), .comp_o(comp_o), .match_o(match_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b (mode=%b cnt=%0d cmp=%0d)",
               tag, act, exp, mode, cnt, cmp);
    end
  endtask

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0:       return "R1";
      3'd1, 3'd2: return "R2";
      3'd3:       return "R3";
      3'd4, 3'd5: return "R4";
      default:    return "R5";
    endcase
  endfunction

  // one clock: inputs already applied on the falling edge
  task automatic cyc();
    bit hit, lo;
    logic exp_main, exp_comp;
    string tm, tc;
    hit = (cnt == cmp);
    lo  = (cnt < cmp);
    @(posedge clk);
    if (mode == 3'd1 && hit) m_ref = 1'b1;
    else if (mode == 3'd2 && hit) m_ref = 1'b0;
    else if (mode == 3'd3 && hit) m_ref = !m_ref;
    else if (mode == 3'd4) m_ref = 1'b0;
    else if (mode == 3'd5) m_ref = 1'b1;
    else if (mode == 3'd6) m_ref = lo;
    else if (mode == 3'd7) m_ref = !lo;
    @(negedge clk);
    if (!master) begin
      exp_main = 1'b0; exp_comp = 1'b0; tm = "R9"; tc = "R9";
    end else begin
      exp_main = main_en ? (m_ref ^ main_pol) : 1'b0;
      exp_comp = comp_en ? (!m_ref ^ comp_pol) : 1'b0;
      tm = main_en ? {mode_tag(mode), "/R6"} : "R8";
      tc = comp_en ? {mode_tag(mode), "/R7"} : "R8";
    end
    chk(tm, main_o, exp_main);
    chk(tc, comp_o, exp_comp);
    chk("R10 match", match_o, hit);
    chk("R10 irq", irq_o, hit && irq_en);
  endtask

  task automatic sweep(logic [2:0] m, logic [15:0] c, logic [15:0] start, int n);
    mode = m;
    cmp  = c;
    for (int i = 0; i < n; i++) begin
      cnt = 16'(start + 16'(i));
      cyc();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cnt = 16'd0; cmp = 16'd0; mode = 3'd1;
    main_pol = 1'b0; comp_pol = 1'b0; main_en = 1'b1; comp_en = 1'b1;
    master = 1'b1; irq_en = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state, cnt==cmp held but flags must stay low
    chk("R11 main", main_o, 1'b0);
    chk("R11 comp", comp_o, 1'b1);
    chk("R11 match", match_o, 1'b0);
    chk("R11 irq", irq_o, 1'b0);
    cnt = 16'd1; cmp = 16'd9;
    rst_n = 1'b1;

    // every mode under every polarity pair
    for (int p = 0; p < 4; p++) begin
      main_pol = p[0];
      comp_pol = p[1];
      for (int m = 0; m < 8; m++) begin
        irq_en = m[0];
        sweep(3'(m), 16'd5, 16'd0, 12);
      end
    end

    // R1: hold after high, then after low
    sweep(3'd5, 16'd5, 16'd0, 2);
    sweep(3'd0, 16'd5, 16'd0, 10);
    sweep(3'd4, 16'd5, 16'd0, 2);
    sweep(3'd0, 16'd5, 16'd0, 10);

    // R3: several toggles across repeated passes
    for (int k = 0; k < 3; k++) sweep(3'd3, 16'd2, 16'd0, 4);

    // R5 boundaries: zero compare and top of range with wrap
    sweep(3'd6, 16'd0, 16'd0, 4);
    sweep(3'd7, 16'd0, 16'd0, 4);
    sweep(3'd6, 16'hFFFF, 16'hFFFC, 6);
    sweep(3'd7, 16'hFFFF, 16'hFFFC, 6);

    // R8/R9: enable gating
    main_pol = 1'b1; comp_pol = 1'b1;
    main_en = 1'b0; comp_en = 1'b1;
    sweep(3'd3, 16'd3, 16'd0, 8);
    main_en = 1'b1; comp_en = 1'b0;
    sweep(3'd3, 16'd3, 16'd0, 8);
    master = 1'b0; main_en = 1'b1; comp_en = 1'b1;
    sweep(3'd5, 16'd3, 16'd0, 4);
    sweep(3'd4, 16'd3, 16'd0, 4);
    master = 1'b1;
    sweep(3'd4, 16'd3, 16'd0, 2);

    // random mix
    for (int i = 0; i < 400; i++) begin
      mode     = 3'($urandom_range(0, 7));
      cmp      = 16'($urandom_range(0, 6));
      cnt      = 16'($urandom_range(0, 6));
      main_pol = 1'($urandom_range(0, 1));
      comp_pol = 1'($urandom_range(0, 1));
      main_en  = ($urandom_range(0, 3) != 0);
      comp_en  = ($urandom_range(0, 3) != 0);
      master   = ($urandom_range(0, 5) != 0);
      irq_en   = 1'($urandom_range(0, 1));
      cyc();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule